// File: doc/BRIEF.md
# Write-Intensity Classifier Table

This block sits beside the write-back path of a last-level cache in front of a non-volatile main memory. For every block leaving the cache it looks up the block's address tag in a small fully associative table and answers, one cycle later, whether that block is write-intensive (active) or inert. The answer steers the encryption path: active blocks use a keystream cipher with a per-block nonce, and inert blocks use a nonce-free cipher. Only active blocks need on-chip nonce storage, so the table keeps that set small.

Each entry keeps a tag and three history flags: the reference flag of the previous period, the reference flag of the present period, and the active flag. A block becomes active when it is written a second time within one period. It falls back to inert when it is written while active after a whole period with no write. A one-cycle period pulse shifts the present reference flag into the previous one. When a miss must replace an entry that is still active, the block emits a re-encryption request carrying the replaced tag, because that block's data was encrypted with a nonce that is about to be lost.

Top module: `wi_flag_table`

## Requirements
- R1: A write whose tag is not in the table installs a new entry with its present-period reference set and the previous reference and active flag clear, and it reports inert (res_active = 0).
- R2: A write that hits an entry whose present-period reference is set and whose active flag is clear sets the active flag and reports active (res_active = 1).
- R3: A write that hits an entry whose active flag is set and whose previous-period reference is clear clears the active flag and reports inert.
- R4: A write that hits an active entry whose previous-period reference is set keeps it active. Every hit sets the present-period reference after the active decision has been taken.
- R5: A cycle with period_tick = 1 copies each entry's present reference into its previous reference and clears the present reference. A write in that same cycle is judged against the shifted flags.
- R6: After reset the table holds no entries, res_valid and reenc_valid are 0, and every block is first reported inert.
- R7: res_valid is 1 in exactly the cycle after each cycle with wb_valid = 1, and 0 otherwise.
- R8: When a miss replaces an entry whose active flag is set, reenc_valid is 1 in the same cycle as that write's result, and reenc_tag carries the replaced tag. Replacing an inert entry raises no request.
- R9: A miss fills the lowest-numbered empty entry first. When the table is full it replaces the least recently used entry, where both a hit and an install make an entry the most recently used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wb_valid | input | 1 | A block is being written back this cycle |
| wb_tag | input | TAG_W | Address tag of the block being written back |
| period_tick | input | 1 | One-cycle pulse at each update period boundary |
| res_valid | output | 1 | Classification result present |
| res_active | output | 1 | 1 = write-intensive (keystream path), 0 = inert |
| reenc_valid | output | 1 | An active entry was replaced; its block must be re-encrypted |
| reenc_tag | output | TAG_W | Tag of the replaced active entry |

## Verification
The classifier runs through one block's full life cycle: a first write, a second write in the same period, a write after one quiet period boundary and a write after two quiet boundaries. These show that promotion, retention and demotion each depend on the right history flag. A period pulse that coincides with a write shows whether the aging is applied before the decision. A run of distinct tags mixed with re-hits fills the table and forces replacements in a known order. This shows whether replacement follows use recency, and it separates active victims, which must raise a request with the right tag, from inert victims, which must not. A reset in the middle of the run, with an active block present, shows that the history is discarded.

// File: rtl/wift_pkg.sv
// Package: shared helpers for the write-intensity classifier table.
// Assumes: nothing beyond IEEE 1800-2017.
package wift_pkg;

    // Result of a write judged against one entry's history flags.
    typedef struct packed {
        logic wi_next;   // active flag after the decision
    } wift_decision_t;

    // Decide the next active flag of a hit entry from its (aged) flags.
    function automatic wift_decision_t wift_decide(
        input logic old_ref,
        input logic cur_ref,
        input logic wr_int
    );
        wift_decision_t d;
        if (cur_ref && !wr_int)
            d.wi_next = 1'b1;          // second write within this period
        else if (wr_int && !old_ref)
            d.wi_next = 1'b0;          // quiet during the previous period
        else
            d.wi_next = wr_int;
        return d;
    endfunction

endpackage

// File: rtl/wift_lookup.sv
// Module: wift_lookup
// Fully associative tag match. Reports whether the key matches any valid
// entry and the index of the lowest matching one.
// Assumes: at most one valid entry carries a given tag (the owner ensures it).
module wift_lookup #(
    parameter int TAG_W = 24,
    parameter int DEPTH = 4,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0][TAG_W-1:0] tags,
    input  logic [DEPTH-1:0]            valid,
    input  logic [TAG_W-1:0]            key,
    output logic                        hit,
    output logic [IDX_W-1:0]            hit_idx
);

    logic [DEPTH-1:0] match;

    // Per-entry comparator.
    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign match[i] = valid[i] && (tags[i] == key);
    end

    // Encode the matching index; the lowest index wins.
    always_comb begin
        hit_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (match[i]) hit_idx = IDX_W'(i);
        end
    end

    assign hit = |match;

endmodule

// File: rtl/wift_lru.sv
// Module: wift_lru
// Recency ranks for the table entries: 0 = most recent, DEPTH-1 = least.
// A touch makes the entry rank 0 and ages every valid entry that was more
// recent than it. An install is treated as a touch of the oldest rank.
// Assumes: ranks of valid entries are distinct and lie below the count of
// valid entries; the update keeps this invariant.
module wift_lru #(
    parameter int DEPTH = 4,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        touch,
    input  logic                        install,
    input  logic [IDX_W-1:0]            touch_idx,
    input  logic [DEPTH-1:0]            valid,
    output logic [DEPTH-1:0][IDX_W-1:0] rank
);

    localparam logic [IDX_W-1:0] OLDEST = IDX_W'(DEPTH - 1);

    logic [IDX_W-1:0] ref_rank;

    // Rank of the touched entry before the update.
    always_comb begin
        ref_rank = install ? OLDEST : rank[touch_idx];
    end

    // Rank update on each touch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rank <= '0;
        end else if (touch) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (IDX_W'(i) == touch_idx)
                    rank[i] <= '0;
                else if (valid[i] && (rank[i] < ref_rank))
                    rank[i] <= rank[i] + 1'b1;
            end
        end
    end

endmodule

// File: rtl/wift_victim.sv
// Module: wift_victim
// Chooses the slot for a new entry: the lowest empty slot when one exists,
// otherwise the slot holding the oldest recency rank.
// Assumes: with all slots valid, exactly one holds rank DEPTH-1.
module wift_victim #(
    parameter int DEPTH = 4,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0]            valid,
    input  logic [DEPTH-1:0][IDX_W-1:0] rank,
    output logic                        slot_free,
    output logic [IDX_W-1:0]            slot_idx
);

    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] old_idx;

    // Lowest empty slot.
    always_comb begin
        slot_free = 1'b0;
        free_idx  = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                slot_free = 1'b1;
                free_idx  = IDX_W'(i);
            end
        end
    end

    // Slot holding the least recently used rank.
    always_comb begin
        old_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rank[i] == IDX_W'(DEPTH - 1)) old_idx = IDX_W'(i);
        end
    end

    assign slot_idx = slot_free ? free_idx : old_idx;

endmodule

// File: rtl/wi_flag_table.sv
// Module: wi_flag_table
// Classifies each written-back block as write-intensive or inert from a
// two-period reference history kept in a small fully associative table.
// The result and any re-encryption request appear one cycle after the write.
// Assumes: DEPTH >= 2; wb_tag is stable while wb_valid is high; period_tick
// is a single-cycle pulse.
module wi_flag_table #(
    parameter int TAG_W = 24,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wb_valid,
    input  logic [TAG_W-1:0] wb_tag,
    input  logic             period_tick,
    output logic             res_valid,
    output logic             res_active,
    output logic             reenc_valid,
    output logic [TAG_W-1:0] reenc_tag
);
    import wift_pkg::*;

    localparam int IDX_W = $clog2(DEPTH);

    // Entry state.
    logic [DEPTH-1:0][TAG_W-1:0] tag_q;
    logic [DEPTH-1:0]            valid_q;
    logic [DEPTH-1:0]            or_q;
    logic [DEPTH-1:0]            cr_q;
    logic [DEPTH-1:0]            wi_q;

    // Flags after the period shift of this cycle.
    logic [DEPTH-1:0]            or_a;
    logic [DEPTH-1:0]            cr_a;

    logic                        hit;
    logic [IDX_W-1:0]            hit_idx;
    logic                        slot_free;
    logic [IDX_W-1:0]            slot_idx;
    logic [DEPTH-1:0][IDX_W-1:0] rank;
    logic                        wr_hit;
    logic                        wr_fill;
    logic [IDX_W-1:0]            touch_idx;
    wift_decision_t              dec;

    // Period aging as seen by this cycle's write.
    always_comb begin
        or_a = period_tick ? cr_q : or_q;
        cr_a = period_tick ? '0   : cr_q;
    end

    wift_lookup #(.TAG_W(TAG_W), .DEPTH(DEPTH)) u_lookup (
        .tags    (tag_q),
        .valid   (valid_q),
        .key     (wb_tag),
        .hit     (hit),
        .hit_idx (hit_idx)
    );

    wift_victim #(.DEPTH(DEPTH)) u_victim (
        .valid     (valid_q),
        .rank      (rank),
        .slot_free (slot_free),
        .slot_idx  (slot_idx)
    );

    assign wr_hit    = wb_valid && hit;
    assign wr_fill   = wb_valid && !hit;
    assign touch_idx = hit ? hit_idx : slot_idx;

    wift_lru #(.DEPTH(DEPTH)) u_lru (
        .clk       (clk),
        .rst_n     (rst_n),
        .touch     (wb_valid),
        .install   (wr_fill),
        .touch_idx (touch_idx),
        .valid     (valid_q),
        .rank      (rank)
    );

    // Decision for the hit entry, taken on the aged flags.
    always_comb begin
        dec = wift_decide(or_a[hit_idx], cr_a[hit_idx], wi_q[hit_idx]);
    end

    // Entry update: aging for all, then the written entry's own change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q   <= '0;
            valid_q <= '0;
            or_q    <= '0;
            cr_q    <= '0;
            wi_q    <= '0;
        end else begin
            or_q <= or_a;
            cr_q <= cr_a;
            for (int i = 0; i < DEPTH; i++) begin
                if (wr_hit && (hit_idx == IDX_W'(i))) begin
                    cr_q[i] <= 1'b1;
                    wi_q[i] <= dec.wi_next;
                end else if (wr_fill && (slot_idx == IDX_W'(i))) begin
                    tag_q[i]   <= wb_tag;
                    valid_q[i] <= 1'b1;
                    or_q[i]    <= 1'b0;
                    cr_q[i]    <= 1'b1;
                    wi_q[i]    <= 1'b0;
                end
            end
        end
    end

    // Registered result and re-encryption request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid   <= 1'b0;
            res_active  <= 1'b0;
            reenc_valid <= 1'b0;
            reenc_tag   <= '0;
        end else begin
            res_valid   <= wb_valid;
            res_active  <= wr_hit && dec.wi_next;
            reenc_valid <= wr_fill && !slot_free && wi_q[slot_idx];
            reenc_tag   <= tag_q[slot_idx];
        end
    end

endmodule

// File: rtl/wi_flag_table_chk.sv
// Module: wi_flag_table_chk
// Temporal checks on the classifier table, attached by bind.
// Assumes: connected to the top module's ports and entry flag vectors.
module wi_flag_table_chk #(
    parameter int DEPTH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wb_valid,
    input logic             period_tick,
    input logic             res_valid,
    input logic             res_active,
    input logic             reenc_valid,
    input logic [DEPTH-1:0] valid_vec,
    input logic [DEPTH-1:0] cr_vec
);

    p_result_after_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |=> res_valid);

    p_no_result_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wb_valid |=> !res_valid);

    p_reenc_on_miss_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reenc_valid |-> (res_valid && !res_active));

    p_reenc_needs_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
        reenc_valid |-> $past(&valid_vec));

    p_fill_monotonic_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(valid_vec) >= $countones($past(valid_vec)));

    p_tick_clears_ref_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (period_tick && !wb_valid) |=> (cr_vec == '0));

    p_quiet_after_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!res_valid && !reenc_valid));

endmodule

bind wi_flag_table wi_flag_table_chk #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wb_valid    (wb_valid),
    .period_tick (period_tick),
    .res_valid   (res_valid),
    .res_active  (res_active),
    .reenc_valid (reenc_valid),
    .valid_vec   (valid_q),
    .cr_vec      (cr_q)
);

// File: tb/wi_flag_table_test.sv
`timescale 1ns/1ps
module wi_flag_table_test;

    localparam int TAG_W = 24;
    localparam int NVEC  = 19;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wb_valid = 1'b0;
    logic [TAG_W-1:0] wb_tag = '0;
    logic             period_tick = 1'b0;
    logic             res_valid;
    logic             res_active;
    logic             reenc_valid;
    logic [TAG_W-1:0] reenc_tag;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    wi_flag_table #(.TAG_W(TAG_W), .DEPTH(4)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .wb_valid    (wb_valid),
        .wb_tag      (wb_tag),
        .period_tick (period_tick),
        .res_valid   (res_valid),
        .res_active  (res_active),
        .reenc_valid (reenc_valid),
        .reenc_tag   (reenc_tag)
    );

    // Vector: {tick, write, tag[7:0], exp_active, exp_reenc, exp_reenc_tag[7:0], req[3:0]}
    localparam logic [23:0] VEC [0:NVEC-1] = '{
        {1'b0, 1'b1, 8'h11, 1'b0, 1'b0, 8'h00, 4'd1}, // R1 first write of A
        {1'b0, 1'b1, 8'h11, 1'b1, 1'b0, 8'h00, 4'd2}, // R2 second write same period
        {1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 4'd5}, // R5 boundary
        {1'b0, 1'b1, 8'h11, 1'b1, 1'b0, 8'h00, 4'd4}, // R4 kept active
        {1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 4'd5}, // R5 boundary
        {1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 4'd5}, // R5 quiet boundary
        {1'b0, 1'b1, 8'h11, 1'b0, 1'b0, 8'h00, 4'd3}, // R3 demoted
        {1'b0, 1'b1, 8'h11, 1'b1, 1'b0, 8'h00, 4'd2}, // R2 promoted again
        {1'b0, 1'b1, 8'h22, 1'b0, 1'b0, 8'h00, 4'd1}, // R1 fill B
        {1'b0, 1'b1, 8'h33, 1'b0, 1'b0, 8'h00, 4'd1}, // R1 fill C
        {1'b0, 1'b1, 8'h44, 1'b0, 1'b0, 8'h00, 4'd9}, // R9 fill D, table full
        {1'b0, 1'b1, 8'h55, 1'b0, 1'b1, 8'h11, 4'd8}, // R8 evict active A
        {1'b0, 1'b1, 8'h22, 1'b1, 1'b0, 8'h00, 4'd9}, // R9 hit B survived
        {1'b0, 1'b1, 8'h66, 1'b0, 1'b0, 8'h00, 4'd8}, // R8 evict inert C
        {1'b0, 1'b1, 8'h44, 1'b1, 1'b0, 8'h00, 4'd9}, // R9 hit D survived
        {1'b0, 1'b1, 8'h77, 1'b0, 1'b0, 8'h00, 4'd9}, // R9 evict inert E
        {1'b0, 1'b1, 8'h88, 1'b0, 1'b1, 8'h22, 4'd8}, // R8 evict active B
        {1'b1, 1'b1, 8'h66, 1'b0, 1'b0, 8'h00, 4'd5}, // R5 tick with write
        {1'b0, 1'b1, 8'h66, 1'b1, 1'b0, 8'h00, 4'd5}  // R5 reference set again
    };

    task automatic check(input string req, input string what,
                         input logic [TAG_W-1:0] act, input logic [TAG_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One cycle of stimulus; outputs sampled at the following falling edge.
    task automatic step(input logic tick, input logic wr, input logic [TAG_W-1:0] tag);
        period_tick = tick;
        wb_valid    = wr;
        wb_tag      = tag;
        @(posedge clk);
        @(negedge clk);
        period_tick = 1'b0;
        wb_valid    = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        // R6: quiet outputs after reset
        check("R6", "res_valid after reset", TAG_W'(res_valid), '0);
        check("R6", "reenc_valid after reset", TAG_W'(reenc_valid), '0);

        for (int v = 0; v < NVEC; v++) begin
            logic [23:0] e;
            string rq;
            e = VEC[v];
            rq = $sformatf("R%0d", e[3:0]);
            step(e[23], e[22], TAG_W'(e[21:14]));
            check(rq, $sformatf("vec %0d res_valid", v), TAG_W'(res_valid), TAG_W'(e[22]));
            if (e[22])
                check(rq, $sformatf("vec %0d res_active", v), TAG_W'(res_active), TAG_W'(e[13]));
            check(rq, $sformatf("vec %0d reenc_valid", v), TAG_W'(reenc_valid), TAG_W'(e[12]));
            if (e[12])
                check(rq, $sformatf("vec %0d reenc_tag", v), reenc_tag, TAG_W'(e[11:4]));
        end

        // R7: an idle cycle yields no result and no request
        step(1'b0, 1'b0, TAG_W'(8'h66));
        check("R7", "idle res_valid", TAG_W'(res_valid), '0);
        check("R8", "idle reenc_valid", TAG_W'(reenc_valid), '0);

        // R6: reset discards history; F was active and now reads inert
        do_reset();
        step(1'b0, 1'b1, TAG_W'(8'h66));
        check("R6", "first write after reset", TAG_W'(res_active), '0);
        step(1'b0, 1'b1, TAG_W'(8'h66));
        check("R2", "second write after reset", TAG_W'(res_active), TAG_W'(1));

        // R1: wide tag uses all bits (differs only in the top bit)
        step(1'b0, 1'b1, {1'b1, 23'h66});
        check("R1", "wide tag miss", TAG_W'(res_active), '0);

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule